// File: doc/BRIEF.md
# Replay FIFO with Rewind and Half-Full Flag

This block is a single-clock first-in/first-out buffer for 9-bit words, with a depth that is a power of two set by a parameter. Write and read requests are strobes sampled on the rising clock edge. A write is accepted unless the buffer is full, and a read is accepted unless it is empty. The top data bit is not interpreted; it may carry parity or a control mark, and it passes through like the other bits.

Three active-low flags report the fill level: empty, full, and more-than-half-full. A small state machine produces them, with four named states. ST_EMPTY means nothing is stored. ST_LOWER covers one word up to half the depth. ST_UPPER covers more than half the depth but less than full. ST_FULL means every slot is used. The transitions are:
- ENTRY: ST_EMPTY to ST_LOWER on any accepted write.
- CROSS_UP: ST_LOWER to ST_UPPER on a write-only cycle taken at exactly half the depth.
- TOP_OFF: ST_UPPER to ST_FULL on a write-only cycle taken at depth minus one.
- DRAIN_TOP: ST_FULL to ST_UPPER on a read-only cycle.
- CROSS_DOWN: ST_UPPER to ST_LOWER on a read-only cycle taken at half plus one.
- DRAIN_OUT: ST_LOWER to ST_EMPTY on a read-only cycle taken at one word.
- REWIND_JUMP: any state to the state that matches the fill level after a rewind.

A read cycle returns its word on the cycle after the request, qualified by a valid strobe. The rewind input returns the read side to location zero without touching the write side, so a message written since reset can be sent again.

Top module: `replay_fifo`

## Requirements
- R1: While reset is low and on the first cycle after it: empty_n is 0, full_n is 1, half_n is 1, rd_valid is 0 and rd_data is 0. Both pointers and the occupancy are zero.
- R2: A write requested while full_n is 0 is ignored. Occupancy and stored data do not change, and the word never appears at the output. A read in the same cycle is still accepted.
- R3: A read requested while empty_n is 0 is ignored. rd_valid stays 0 on the next cycle, and the state does not change.
- R4: empty_n is 0 exactly when occupancy is zero.
- R5: full_n goes to 0 on the cycle after the write that fills the last free slot, and stays 0 exactly while occupancy equals the depth.
- R6: half_n is 0 exactly while occupancy is greater than half the depth. It sets on the write that crosses that level and clears on the read that returns to it.
- R7: Words leave in the order they were accepted, with all 9 bits unchanged, bit 8 included.
- R8: An accepted read makes rd_valid 1 for the next cycle, and rd_data then holds the word. In every other cycle rd_valid is 0 and rd_data is 0.
- R9: When a read and a write are both accepted in one cycle, occupancy and flags are unchanged and both pointers advance.
- R10: A rewind taken with both requests low moves the read pointer to location zero and leaves the write pointer as it is. The occupancy becomes the number of words written since reset, which must be at most the depth. The flags follow from that occupancy, and the stored words replay from the first.
- R11: A rewind taken while either request is high is ignored, and the requested operations proceed as usual.
- R12: Both pointers wrap from depth minus one to zero, and the word order holds across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write strobe |
| wr_data | input | 9 | Word to store |
| rd_req | input | 1 | Read strobe |
| rewind | input | 1 | Return read side to location zero |
| rd_data | output | 9 | Word read; zero when not valid |
| rd_valid | output | 1 | rd_data carries a word this cycle |
| empty_n | output | 1 | Low when nothing is stored |
| full_n | output | 1 | Low when every slot is used |
| half_n | output | 1 | Low when more than half is used |

## Verification
The bench builds the block with ADDR_W set to 3, which gives a depth of eight and a half level of four. With that depth, a handful of writes reaches every flag state. The full boundary, the ignored overflow write and the pointer wrap are all reached within a few dozen cycles. It also makes a rewind from a full buffer, which requires exactly eight writes since reset, short enough to repeat alongside a partial-fill rewind.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOWER = 2'd1,
        ST_UPPER = 2'd2,
        ST_FULL  = 2'd3
    } fill_state_t;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // output register: data only during a read cycle, zero otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (re) begin
            rdata  <= mem[raddr];
            rvalid <= 1'b1;
        end else begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end
    end

    p_valid_follows_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> rvalid);
    p_zero_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> (!rvalid && rdata == '0));
endmodule

// File: rtl/rf_pointers.sv
module rf_pointers #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic              rd_ok,
    input  logic              rewind_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   count,
    output logic [ADDR_W:0]   rewind_level
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] DEPTH_C = ADDR_W'(0) + (ADDR_W+1)'(DEPTH);

    // write pointer carries one extra lap bit so a rewind can tell 0 from DEPTH
    logic [ADDR_W:0]   wr_ext;
    logic [ADDR_W-1:0] rd_ptr;

    assign waddr = wr_ext[ADDR_W-1:0];
    assign raddr = rd_ptr;
    assign rewind_level = (wr_ext > DEPTH_C) ? DEPTH_C : wr_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ext <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (rewind_ok) begin
            rd_ptr <= '0;
            count  <= rewind_level;
        end else begin
            if (wr_ok) wr_ext <= wr_ext + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    p_rewind_ptrs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_ok |=> (rd_ptr == '0 && wr_ext == $past(wr_ext)));
    p_both_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && rd_ok && !rewind_ok) |=> $stable(count));
    p_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && !rewind_ok && rd_ptr == ADDR_W'(DEPTH-1)) |=> rd_ptr == '0);
endmodule

// File: rtl/rf_flag_fsm.sv
module rf_flag_fsm
    import replay_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ok,
    input  logic            rd_ok,
    input  logic            rewind_ok,
    input  logic [ADDR_W:0] count,
    input  logic [ADDR_W:0] rewind_level,
    output logic            empty_n,
    output logic            full_n,
    output logic            half_n
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;
    localparam logic [ADDR_W:0] C_HALF   = (ADDR_W+1)'(HALF);
    localparam logic [ADDR_W:0] C_HALF1  = (ADDR_W+1)'(HALF + 1);
    localparam logic [ADDR_W:0] C_TOPM1  = (ADDR_W+1)'(DEPTH - 1);
    localparam logic [ADDR_W:0] C_DEPTH  = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] C_ONE    = (ADDR_W+1)'(1);

    fill_state_t state, nxt;

    function automatic fill_state_t classify(input logic [ADDR_W:0] lvl);
        if (lvl == '0)           return ST_EMPTY;
        else if (lvl <= C_HALF)  return ST_LOWER;
        else if (lvl < C_DEPTH)  return ST_UPPER;
        else                     return ST_FULL;
    endfunction

    logic wr_only, rd_only;
    assign wr_only = wr_ok && !rd_ok;
    assign rd_only = rd_ok && !wr_ok;

    always_comb begin
        nxt = state;
        if (rewind_ok) begin
            nxt = classify(rewind_level);                         // REWIND_JUMP
        end else begin
            unique case (state)
                ST_EMPTY: if (wr_ok) nxt = ST_LOWER;              // ENTRY
                ST_LOWER: begin
                    if (wr_only && count == C_HALF)      nxt = ST_UPPER; // CROSS_UP
                    else if (rd_only && count == C_ONE)  nxt = ST_EMPTY; // DRAIN_OUT
                end
                ST_UPPER: begin
                    if (wr_only && count == C_TOPM1)     nxt = ST_FULL;  // TOP_OFF
                    else if (rd_only && count == C_HALF1) nxt = ST_LOWER; // CROSS_DOWN
                end
                ST_FULL:  if (rd_only) nxt = ST_UPPER;            // DRAIN_TOP
                default:  nxt = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        empty_n = 1'b1;
        full_n  = 1'b1;
        half_n  = 1'b1;
        unique case (state)
            ST_EMPTY: empty_n = 1'b0;
            ST_LOWER: ;
            ST_UPPER: half_n = 1'b0;
            ST_FULL: begin
                half_n = 1'b0;
                full_n = 1'b0;
            end
            default: empty_n = 1'b0;
        endcase
    end

    p_empty_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) == (count == '0));
    p_full_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) == (count == C_DEPTH));
    p_half_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPPER || state == ST_FULL) == (count > C_HALF));
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    logic              wr_ok, rd_ok, rewind_ok;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   count, rewind_level;

    // each pointer moves only while its blocking flag is clear
    assign wr_ok     = wr_req && full_n;
    assign rd_ok     = rd_req && empty_n;
    assign rewind_ok = rewind && !wr_req && !rd_req;

    rf_pointers #(.ADDR_W(ADDR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .rewind_ok(rewind_ok), .waddr(waddr), .raddr(raddr),
        .count(count), .rewind_level(rewind_level)
    );

    rf_storage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
        .re(rd_ok), .raddr(raddr), .rdata(rd_data), .rvalid(rd_valid)
    );

    rf_flag_fsm #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .rewind_ok(rewind_ok), .count(count), .rewind_level(rewind_level),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_req && !rd_req) |=> !full_n);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_req) |=> !rd_valid);
    p_flag_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (!half_n && empty_n));
    p_rewind_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && rd_req && empty_n) |=> rd_valid);
endmodule

// File: tb/replay_fifo_test.sv
module replay_fifo_test;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = DEPTH / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_req = 1'b0, rd_req = 1'b0, rewind = 1'b0;
    logic [8:0] wr_data = '0;
    logic [8:0] rd_data;
    logic       rd_valid, empty_n, full_n, half_n;

    int checks = 0;
    int fails  = 0;
    logic [8:0] q[$];
    logic [8:0] hist[$];

    always #10 clk = ~clk;

    replay_fifo #(.DATA_W(9), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rewind(rewind), .rd_data(rd_data),
        .rd_valid(rd_valid), .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag, input bit ev, input logic [8:0] ed);
        int n;
        n = q.size();
        chk(tag, "empty_n",  int'(empty_n),  int'(n != 0));
        chk(tag, "full_n",   int'(full_n),   int'(n != DEPTH));
        chk(tag, "half_n",   int'(half_n),   int'(n <= HALF));
        chk(tag, "rd_valid", int'(rd_valid), int'(ev));
        chk(tag, "rd_data",  int'(rd_data),  int'(ev ? ed : 9'd0));
    endtask

    // drive at negedge, model at posedge, compare at the following negedge
    task automatic step(input bit w, input logic [8:0] d, input bit r, input bit rw, input string tag);
        bit         can_r, can_w, ev;
        logic [8:0] ed;
        wr_req = w; wr_data = d; rd_req = r; rewind = rw;
        @(posedge clk);
        ev = 1'b0; ed = '0;
        if (rw && !w && !r) begin
            q = hist;
        end else begin
            can_r = (q.size() != 0);
            can_w = (q.size() != DEPTH);
            if (r && can_r) begin ed = q.pop_front(); ev = 1'b1; end
            if (w && can_w) begin
                q.push_back(d);
                if (hist.size() < DEPTH) hist.push_back(d);
            end
        end
        @(negedge clk);
        check_all(tag, ev, ed);
    endtask

    task automatic do_reset();
        wr_req = 0; rd_req = 0; rewind = 0; wr_data = '0;
        rst_n = 1'b0;
        q.delete(); hist.delete();
        repeat (2) @(negedge clk);
        check_all("R1", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 1'b0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        do_reset();

        // R3: reads on an empty buffer do nothing
        step(0, 9'h000, 1, 0, "R3");
        step(0, 9'h000, 1, 0, "R3");

        // R7: small burst with bit 8 set and clear
        step(1, 9'h1A5, 0, 0, "R7");
        step(1, 9'h05A, 0, 0, "R7");
        step(1, 9'h100, 0, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 9'h000, 1, 0, "R7");
        step(0, 9'h000, 1, 0, "R3");

        // R6 / R5 / R2: fill to the top, then push once more
        for (int i = 0; i < DEPTH; i++)
            step(1, 9'(9'h120 + i), 0, 0, (i == HALF) ? "R6" : ((i == DEPTH-1) ? "R5" : "R4"));
        step(1, 9'h1FF, 0, 0, "R2");
        step(1, 9'h1EE, 1, 0, "R2");   // read taken, write blocked
        // R6: drain through the half level, R12: pointers wrap during refill
        for (int i = 0; i < DEPTH - 1; i++) step(0, 9'h000, 1, 0, "R6");
        step(0, 9'h000, 1, 0, "R4");

        // R9: simultaneous traffic at mid level, crossing the wrap (R12)
        for (int i = 0; i < 3; i++) step(1, 9'(9'h040 + i), 0, 0, "R12");
        for (int i = 0; i < 10; i++) step(1, 9'(9'h080 + i), 1, 0, "R9");
        for (int i = 0; i < 3; i++) step(0, 9'h000, 1, 0, "R12");
        // R9 on empty: write accepted, read blocked
        step(1, 9'h0C3, 1, 0, "R9");
        step(0, 9'h000, 1, 0, "R7");

        // R10: partial fill, partial drain, rewind replays from the start
        do_reset();
        for (int i = 0; i < 5; i++) step(1, 9'(9'h150 + i), 0, 0, "R10");
        for (int i = 0; i < 3; i++) step(0, 9'h000, 1, 0, "R10");
        step(0, 9'h000, 0, 1, "R10");
        // R11: rewind with a read pending is a plain read
        step(0, 9'h000, 1, 1, "R11");
        step(0, 9'h000, 1, 1, "R11");
        step(0, 9'h000, 0, 1, "R10");
        for (int i = 0; i < 6; i++) step(0, 9'h000, 1, 0, "R10");
        // R11: rewind with a write pending is a plain write
        do_reset();
        step(1, 9'h011, 0, 0, "R11");
        step(0, 9'h000, 1, 0, "R11");
        step(1, 9'h022, 0, 1, "R11");
        step(0, 9'h000, 1, 0, "R11");
        step(0, 9'h000, 1, 0, "R3");

        // R10: rewind after exactly DEPTH writes restores full
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 9'(9'h1C0 + i), 0, 0, "R5");
        for (int i = 0; i < DEPTH; i++) step(0, 9'h000, 1, 0, "R10");
        step(0, 9'h000, 0, 1, "R10");
        for (int i = 0; i < DEPTH; i++) step(0, 9'h000, 1, 0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule